// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A synthesizable behavioural model of a clocked burst memory. Each word is 36 bits wide and split into four 9-bit lanes. The depth is set by a parameter. An access starts when one of two address strobes is sampled low while the chip is selected. The address is captured into a register, and its two low bits seed a 2-bit burst sequence. On later edges with no strobe, a low advance input moves to the next location of the burst, and a high advance input repeats the current location. The burst walks the four words of an aligned group, in either wrap-around order or XOR order, as chosen by a strap input.

Writes happen on the same edge as the access. They cover either all lanes or a chosen subset of lanes. Reads are pipelined: the location accessed at one edge is loaded into an output register at the next edge. That register drives the data pins only while the asynchronous output enable is low. When the pins are released, `dq_oe_o` is low and `rdata_o` reads zero.

Top module: `sync_burst_sram`

## Requirements
- R1: The chip is selected on a strobe edge only when `chip_sel_a_ni` is low, `chip_sel_b_i` is high and `chip_sel_c_ni` is low. A strobe taken while not selected moves the block to the idle (deselected) state. In that state no location is accessed until the next selected strobe.
- R2: When both strobes are low and the processor-side strobe is qualified, only the processor-side strobe acts. An edge taken by the processor-side strobe always starts a read, and the write inputs have no effect on it.
- R3: The processor-side strobe (`strobe_cpu_ni`) is ignored while `chip_sel_a_ni` is high, and an active burst then carries on. The controller-side strobe (`strobe_ctl_ni`) has no such gating.
- R4: A taken strobe accesses `addr_i` at once. `addr_i[1:0]` becomes the burst start, and the upper bits stay fixed for the rest of the burst.
- R5: On an edge with no taken strobe while selected, `step_ni` low advances to the next burst location, and `step_ni` high accesses the same location again.
- R6: With `order_i` = 0, the low address bits after k advances are (start + k) mod 4, for example 1,2,3,0.
- R7: With `order_i` = 1, the low address bits after k advances are start XOR k, for example 1,0,3,2.
- R8: `wr_all_ni` low on an access edge not taken by the processor-side strobe writes all four lanes, whatever the lane selects and `byte_wr_en_ni` are. Lane i is `wdata_i[9i+8:9i]`.
- R9: Otherwise, lane i is written only when `byte_wr_en_ni` is low and `lane_sel_ni[i]` is low. When both `wr_all_ni` and `byte_wr_en_ni` are high, the access is a read and the memory is unchanged.
- R10: A read accessed at edge k shows on `rdata_o` after edge k+1, holding the contents stored before that edge's write.
- R11: `dq_oe_o` is high, and `rdata_o` carries the read word, only while a read result is held and `out_en_ni` is low. This path is combinational from `out_en_ni`. Otherwise `dq_oe_o` is 0 and `rdata_o` is 0.
- R12: After a read starts from the idle state, the outputs stay released during the following cycle, even with `out_en_ni` low.
- R13: While `rst_ni` is low, the block is idle, holds no read result and releases its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| order_i | input | 1 | Burst order strap: 0 wrap-around, 1 XOR |
| addr_i | input | AW | Word address captured on a taken strobe |
| strobe_cpu_ni | input | 1 | Processor-side address strobe, active low, higher priority |
| strobe_ctl_ni | input | 1 | Controller-side address strobe, active low |
| chip_sel_a_ni | input | 1 | Chip select, active low; also gates the processor-side strobe |
| chip_sel_b_i | input | 1 | Chip select, active high |
| chip_sel_c_ni | input | 1 | Chip select, active low |
| step_ni | input | 1 | Burst advance, active low |
| wr_all_ni | input | 1 | Write all lanes, active low |
| byte_wr_en_ni | input | 1 | Lane write enable, active low |
| lane_sel_ni | input | 4 | Per-lane write selects, active low |
| wdata_i | input | 36 | Write data |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 36 | Read data, zero while released |
| dq_oe_o | output | 1 | High while the data outputs are driven |

## Verification
The hardest cases to reach from the ports are those that depend on the internal idle/active state. Examples are a burst that keeps running through a cycle with a gated processor-side strobe, and the released output cycle right after leaving the idle state. The stimulus reaches these states on purpose: it starts a burst, then pulses the processor-side strobe with the first select high, and it runs a strobe with a failing select just before a read. Strobe priority is only visible when a write is presented with both strobes low. The stimulus follows such a cycle with a read of the same word, which shows that the old contents survived.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned BURST_W = 2;

  typedef enum logic {
    ORD_WRAP = 1'b0,
    ORD_XOR  = 1'b1
  } burst_order_e;

  function automatic logic [BURST_W-1:0] burst_low(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] step,
    input logic               order
  );
    if (burst_order_e'(order) == ORD_XOR) return start ^ step;
    return start + step;
  endfunction
endpackage

// File: rtl/access_ctrl.sv
module access_ctrl #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_cpu_ni,
  input  logic             strobe_ctl_ni,
  input  logic             chip_sel_a_ni,
  input  logic             chip_sel_b_i,
  input  logic             chip_sel_c_ni,
  input  logic             step_ni,
  input  logic             wr_all_ni,
  input  logic             byte_wr_en_ni,
  input  logic [LANES-1:0] lane_sel_ni,
  output logic             load_o,
  output logic             adv_o,
  output logic             rd_o,
  output logic [LANES-1:0] wr_lanes_o,
  output logic             start_idle_o
);
  logic active_q;
  logic selected, cpu_take, ctl_take, strobe, cont, acc, wr_req;
  logic [LANES-1:0] lanes;

  always_comb begin
    selected = !chip_sel_a_ni && chip_sel_b_i && !chip_sel_c_ni;
    cpu_take = !strobe_cpu_ni && !chip_sel_a_ni;
    ctl_take = !strobe_ctl_ni && !cpu_take;
    strobe   = cpu_take || ctl_take;
    load_o   = strobe && selected;
    cont     = !strobe && active_q;
    acc      = load_o || cont;
    adv_o    = cont && !step_ni;
    // processor-side strobe edge is always a read start
    wr_req   = !cpu_take && (!wr_all_ni || !byte_wr_en_ni);
    if (!wr_all_ni)          lanes = '1;
    else if (!byte_wr_en_ni) lanes = ~lane_sel_ni;
    else                     lanes = '0;
    wr_lanes_o   = (acc && wr_req) ? lanes : '0;
    rd_o         = acc && !wr_req;
    start_idle_o = load_o && !active_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= 1'b0;
    else if (strobe) active_q <= selected;
  end

  a_r2_cpu_edge_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_cpu_ni && !chip_sel_a_ni) |-> (wr_lanes_o == '0))
    else $error("R2 write on processor strobe edge");

  a_r1_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_ctl_ni && strobe_cpu_ni && !chip_sel_b_i) |=> (!rd_o && wr_lanes_o == '0 && !adv_o)
      || !strobe_ctl_ni || !strobe_cpu_ni)
    else $error("R1 access after deselecting strobe");

  a_r8_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_all_ni && strobe_cpu_ni && (load_o || adv_o)) |-> (wr_lanes_o == '1))
    else $error("R8 global write missed a lane");

  a_r3_gated_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_sel_a_ni && strobe_ctl_ni) |-> !load_o)
    else $error("R3 gated processor strobe loaded");
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import sram_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          order_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] acc_addr_o
);
  localparam int unsigned HW = AW - BURST_W;

  logic [HW-1:0]      hi_q, hi_n;
  logic [BURST_W-1:0] start_q, start_n, cnt_q, cnt_n;

  always_comb begin
    hi_n    = load_i ? addr_i[AW-1:BURST_W] : hi_q;
    start_n = load_i ? addr_i[BURST_W-1:0] : start_q;
    if (load_i)     cnt_n = '0;
    else if (adv_i) cnt_n = cnt_q + 1'b1;
    else            cnt_n = cnt_q;
    acc_addr_o = {hi_n, burst_low(start_n, cnt_n, order_i)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else begin
      hi_q    <= hi_n;
      start_q <= start_n;
      cnt_q   <= cnt_n;
    end
  end

  a_r4_load_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (start_q == $past(addr_i[BURST_W-1:0]) && cnt_q == '0))
    else $error("R4 burst start not seeded");

  a_r5_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> (cnt_q == $past(cnt_q) + 1'b1))
    else $error("R5 burst did not advance");

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(cnt_q) && $stable(hi_q))
    else $error("R5 burst moved without advance");
endmodule

// File: rtl/lane_mem.sv
module lane_mem #(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 4,
  parameter int unsigned LW    = 9
) (
  input  logic                clk_i,
  input  logic [AW-1:0]       waddr_i,
  input  logic [LANES-1:0]    we_i,
  input  logic [LANES*LW-1:0] wdata_i,
  input  logic                re_i,
  input  logic [AW-1:0]       raddr_i,
  output logic [LANES*LW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] store [DEPTH];
    logic [LW-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i[g]) store[waddr_i] <= wdata_i[g*LW +: LW];
      if (re_i)    rd_q <= store[raddr_i];
    end

    assign rdata_o[g*LW +: LW] = rd_q;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 4,
  parameter int unsigned LW    = 9,
  localparam int unsigned DW   = LANES * LW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             order_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             strobe_cpu_ni,
  input  logic             strobe_ctl_ni,
  input  logic             chip_sel_a_ni,
  input  logic             chip_sel_b_i,
  input  logic             chip_sel_c_ni,
  input  logic             step_ni,
  input  logic             wr_all_ni,
  input  logic             byte_wr_en_ni,
  input  logic [LANES-1:0] lane_sel_ni,
  input  logic [DW-1:0]    wdata_i,
  input  logic             out_en_ni,
  output logic [DW-1:0]    rdata_o,
  output logic             dq_oe_o
);
  logic             load, adv, rd, start_idle;
  logic [LANES-1:0] wr_lanes;
  logic [AW-1:0]    acc_addr, rd_addr_q;
  logic             rd_pend_q, dvalid_q;
  logic [DW-1:0]    mem_q;

  access_ctrl #(.LANES(LANES)) u_ctrl (
    .clk_i, .rst_ni, .strobe_cpu_ni, .strobe_ctl_ni,
    .chip_sel_a_ni, .chip_sel_b_i, .chip_sel_c_ni, .step_ni,
    .wr_all_ni, .byte_wr_en_ni, .lane_sel_ni,
    .load_o(load), .adv_o(adv), .rd_o(rd), .wr_lanes_o(wr_lanes),
    .start_idle_o(start_idle)
  );

  burst_addr_gen #(.AW(AW)) u_addr (
    .clk_i, .rst_ni, .load_i(load), .adv_i(adv), .order_i,
    .addr_i, .acc_addr_o(acc_addr)
  );

  lane_mem #(.AW(AW), .LANES(LANES), .LW(LW)) u_mem (
    .clk_i, .waddr_i(acc_addr), .we_i(wr_lanes), .wdata_i,
    .re_i(rd_pend_q), .raddr_i(rd_addr_q), .rdata_o(mem_q)
  );

  // stage 1: address captured; stage 2: output register loads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      dvalid_q  <= 1'b0;
    end else begin
      rd_pend_q <= rd;
      if (rd) rd_addr_q <= acc_addr;
      dvalid_q  <= rd_pend_q;
    end
  end

  assign dq_oe_o = dvalid_q && !out_en_ni;
  assign rdata_o = dq_oe_o ? mem_q : '0;

  a_r12_idle_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_idle |=> !dq_oe_o)
    else $error("R12 outputs driven on first cycle out of idle");

  a_r10_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> ##1 dvalid_q)
    else $error("R10 read result not held two edges later");

  a_r11_oe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !out_en_ni)
    else $error("R11 driven with enable high");

  a_r11_released_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> (rdata_o == '0))
    else $error("R11 released outputs not zero");
endmodule

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic order, cpu_n, ctl_n, cs_a_n, cs_b, cs_c_n, step_n, wall_n, ben_n, oe_n;
  logic [AW-1:0] addr;
  logic [3:0] lane_n;
  logic [DW-1:0] wdata, rdata;
  logic dq_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sync_burst_sram #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .order_i(order), .addr_i(addr),
    .strobe_cpu_ni(cpu_n), .strobe_ctl_ni(ctl_n),
    .chip_sel_a_ni(cs_a_n), .chip_sel_b_i(cs_b), .chip_sel_c_ni(cs_c_n),
    .step_ni(step_n), .wr_all_ni(wall_n), .byte_wr_en_ni(ben_n),
    .lane_sel_ni(lane_n), .wdata_i(wdata), .out_en_ni(oe_n),
    .rdata_o(rdata), .dq_oe_o(dq_oe)
  );

  // reference state
  logic [DW-1:0] ref_mem [1 << AW];
  bit m_active = 0;
  logic [AW-3:0] m_hi = '0;
  logic [1:0] m_start = '0, m_cnt = '0;
  bit pend_v = 0;
  logic [AW-1:0] pend_a = '0;

  bit            q_drv [$];
  logic [DW-1:0] q_dat [$];
  string         q_tag [$];

  task automatic check(string tag, bit ok, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_idle();
    cpu_n = 1; ctl_n = 1; cs_a_n = 0; cs_b = 1; cs_c_n = 0;
    step_n = 1; wall_n = 1; ben_n = 1; lane_n = 4'hF; oe_n = 0;
    addr = '0; wdata = '0;
  endtask

  // one clock: push the expected output after the coming edge, then model it
  task automatic tick(string tag);
    bit sel, cpu, ctl, acc, wr;
    logic [3:0] mask;
    logic [1:0] low;
    logic [AW-1:0] a;
    q_drv.push_back(pend_v && !oe_n);
    q_dat.push_back((pend_v && !oe_n) ? ref_mem[pend_a] : '0);
    q_tag.push_back(tag);
    sel = !cs_a_n && cs_b && !cs_c_n;
    cpu = !cpu_n && !cs_a_n;
    ctl = !ctl_n && !cpu;
    acc = 0; wr = 0;
    if (cpu || ctl) begin
      if (sel) begin
        m_active = 1; m_hi = addr[AW-1:2]; m_start = addr[1:0]; m_cnt = 0;
        acc = 1; wr = ctl && (!wall_n || !ben_n);
      end else m_active = 0;
    end else if (m_active) begin
      if (!step_n) m_cnt = m_cnt + 1;
      acc = 1; wr = !wall_n || !ben_n;
    end
    low = order ? (m_start ^ m_cnt) : (m_start + m_cnt);
    a = {m_hi, low};
    if (acc && wr) begin
      mask = !wall_n ? 4'hF : ~lane_n;
      for (int i = 0; i < 4; i++)
        if (mask[i]) ref_mem[a][i*9 +: 9] = wdata[i*9 +: 9];
      pend_v = 0;
    end else begin
      pend_v = acc;
      pend_a = a;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_start(logic [AW-1:0] ad, logic [DW-1:0] d, string tag);
    set_idle(); ctl_n = 0; wall_n = 0; addr = ad; wdata = d; tick(tag);
  endtask
  task automatic wr_next(logic [DW-1:0] d, string tag);
    set_idle(); step_n = 0; wall_n = 0; wdata = d; tick(tag);
  endtask
  task automatic rd_start(logic [AW-1:0] ad, string tag);
    set_idle(); cpu_n = 0; addr = ad; tick(tag);
  endtask
  task automatic rd_next(string tag);
    set_idle(); step_n = 0; tick(tag);
  endtask

  // monitor: compare after every edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_drv.size() > 0) begin
        bit e_drv;
        logic [DW-1:0] e_dat;
        string t;
        e_drv = q_drv.pop_front(); e_dat = q_dat.pop_front(); t = q_tag.pop_front();
        check(t, dq_oe === e_drv && rdata === e_dat, {dq_oe, rdata}, {e_drv, e_dat});
      end
    end
  end

  initial begin
    for (int i = 0; i < 30000; i++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    order = 0;
    set_idle();
    cs_a_n = 1;
    for (int i = 0; i < 3; i++) @(posedge clk);
    @(negedge clk);
    check("R13 reset release", dq_oe === 1'b0 && rdata === '0, {dq_oe, rdata}, '0);
    rst_n = 1;

    // R6 R8: wrap-around write burst from start 1 -> 9,10,11,8
    wr_start(6'd9,  36'h1_1111_1111, "R8 global write");
    wr_next(36'h2_2222_2222, "R6 wrap write");
    wr_next(36'h3_3333_3333, "R6 wrap write");
    wr_next(36'h4_4444_4444, "R6 wrap write");
    // R10 R4: read burst from 8 -> 8,9,10,11
    rd_start(6'd8, "R4 load read");
    rd_next("R10 read latency");
    rd_next("R5 advance read");
    rd_next("R6 wrap read");
    set_idle(); tick("R5 hold read");
    set_idle(); tick("R10 read data");

    // R1 deselect then R12 first read out of idle
    set_idle(); ctl_n = 0; cs_b = 0; tick("R1 deselect");
    set_idle(); tick("R1 idle no access");
    rd_start(6'd9, "R12 idle start");
    set_idle(); tick("R12 masked cycle");
    set_idle(); tick("R12 data after mask");

    // R7: XOR order write from 0x15 -> 21,20,23,22
    order = 1;
    wr_start(6'h15, 36'hA_0000_0001, "R7 xor write");
    wr_next(36'hA_0000_0002, "R7 xor write");
    wr_next(36'hA_0000_0003, "R7 xor write");
    wr_next(36'hA_0000_0004, "R7 xor write");
    order = 0;
    for (int i = 0; i < 4; i++) begin
      set_idle(); ctl_n = 0; addr = 6'h14 + 6'(i); tick("R7 xor readback");
    end
    set_idle(); tick("R7 xor readback");

    // R9: lane writes
    wr_start(6'h30, 36'hF_FFFF_FFFF, "R8 fill");
    set_idle(); ctl_n = 0; addr = 6'h30; ben_n = 0; lane_n = 4'b1010;
    wdata = 36'h0_0000_0000; tick("R9 lane write");
    set_idle(); ctl_n = 0; addr = 6'h30; lane_n = 4'b0000;
    wdata = 36'h5_5555_5555; tick("R9 no enable is read");
    set_idle(); ctl_n = 0; addr = 6'h30; wall_n = 0; ben_n = 1; lane_n = 4'b1111;
    wdata = 36'h1_2345_6789; tick("R8 ignores lane selects");
    rd_start(6'h30, "R9 readback");
    set_idle(); tick("R9 readback");
    set_idle(); tick("R9 readback");

    // R2: both strobes with write -> read only
    wr_start(6'h31, 36'hC_AFE0_0001, "R2 setup");
    set_idle(); cpu_n = 0; ctl_n = 0; wall_n = 0; addr = 6'h31;
    wdata = 36'hD_EAD0_0002; tick("R2 priority");
    set_idle(); tick("R2 old data kept");
    set_idle(); tick("R2 old data kept");

    // R3: gated processor strobe does not break the burst
    rd_start(6'd8, "R3 start");
    set_idle(); cpu_n = 0; cs_a_n = 1; step_n = 0; tick("R3 gated strobe");
    set_idle(); tick("R3 continue");
    set_idle(); ctl_n = 0; cs_a_n = 1; tick("R3 ctl not gated");
    set_idle(); tick("R3 idle");
    set_idle(); tick("R3 idle");

    // R11: enable high releases outputs
    rd_start(6'd10, "R11 start");
    set_idle(); oe_n = 1; tick("R11 enable high");
    set_idle(); oe_n = 1; tick("R11 enable high");
    set_idle(); tick("R11 enable low");
    set_idle(); tick("R11 enable low");

    // R5 hold repeats same location
    rd_start(6'h14, "R5 hold start");
    set_idle(); tick("R5 hold");
    set_idle(); tick("R5 hold");
    set_idle(); tick("R5 hold");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule